// File: doc/BRIEF.md
# Systolic Montgomery Modular Exponentiator

This block raises a message to a power modulo an odd modulus with the right-to-left square-and-multiply method. Every modular product is a Montgomery product: it returns X·Y·2^-W mod N, where W is the operand width. The block does no conversion into or out of the Montgomery domain. A caller that wants a plain modular power applies those conversions outside the block.

One bit-serial accumulation datapath serves both operations. Even cycles advance the squaring of the running power A. Odd cycles advance the multiplication of the running product B by A. Both slots use the same parallel operand, the register holding A. One wrap cycle after each pass writes the reduced results back. The new A is captured there, and B is either updated or kept unchanged. The same wrap cycle reloads the serial shift registers for the next pass.

To start a run, the caller presents the message, the exponent, the modulus N and its half-value (N+1)/2, and pulses `start`. The block copies these operands, raises `busy` for a fixed number of cycles, then pulses `done`. On that pulse, the final B appears on `result` and stays there until the next run finishes.

Top module: `mont_exp_systolic`

## Requirements
- R1: While reset is applied and after it is released, `busy`, `done` and `result` are all zero.
- R2: A `start` pulse seen while idle makes `busy` high from the next cycle on, and `busy` stays high for exactly W·(2W+3) cycles.
- R3: `done` is high for exactly one cycle. That cycle is the first cycle after `busy` falls.
- R4: On `done`, `result` equals the final B of the following sequence, and it is below N. The sequence is: A=M; B=M if exponent bit 0 is 1, else B=1; then for each exponent bit i=1..W-1, A := A·A·2^-W mod N, and, only if bit i is 1, B := A·B·2^-W mod N using that new A.
- R5: With exponent 0 the result is 1. With only bit 0 set, the result is M, because a zero exponent bit leaves B unchanged.
- R6: A `start` pulse while `busy` is high is ignored. The completion time and the result are those of the run already in progress.
- R7: `result` holds its value in every cycle where `done` is low.
- R8: An exponent with all W bits set, which makes every multiply slot active, yields the R4 value.
- R9: The extremes of the operand range yield the R4 value: the largest modulus 2^W-1 with message N-1, and the smallest modulus 3.
- R10: Changes to `msg`, `expo`, `modulus` and `mod_half` after the accepting `start` have no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; taken only while idle |
| msg | input | W | Message M, below N |
| expo | input | W | Exponent, bit 0 first in processing order |
| modulus | input | W | Odd modulus N, at least 3 |
| mod_half | input | W | (N+1)/2, supplied by the caller |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | W | Final B of the last completed run |

## Verification
The hardest situation to reach from the ports is an accumulator that comes close to twice the modulus at the end of a pass, since only then is the final conditional subtraction used in a way that matters. The stimulus reaches it with the largest odd modulus and a message of N-1 under an all-ones exponent. Many random odd moduli and exponents follow. A second hard case is a start pulse arriving mid-run together with changed operands. The bench sends both partway through one run, and its cycle model requires the original timing and the original result.

// File: rtl/mexp_pkg.sv
package mexp_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_WRAP = 2'd2
    } phase_e;
endpackage

// File: rtl/mexp_step.sv
// One accumulation step: acc' = floor(acc/2) + acc[0]*half + bit*operand
module mexp_step #(
    parameter int W  = 8,
    parameter int PW = W + 2
) (
    input  logic [PW-1:0] p_in,
    input  logic          ser_bit,
    input  logic [W-1:0]  par_op,
    input  logic [W-1:0]  nhalf,
    output logic [PW-1:0] p_out
);
    logic [PW-1:0] halved;
    logic [PW-1:0] add_q;
    logic [PW-1:0] add_b;

    always_comb begin
        halved = {1'b0, p_in[PW-1:1]};
        add_q  = p_in[0] ? PW'(nhalf) : '0;
        add_b  = ser_bit ? PW'(par_op) : '0;
        p_out  = halved + add_q + add_b;
    end
endmodule

// File: rtl/mexp_reduce.sv
// Final correction: accumulator below 2N brought below N
module mexp_reduce #(
    parameter int W  = 8,
    parameter int PW = W + 2
) (
    input  logic [PW-1:0] acc,
    input  logic [W-1:0]  nmod,
    output logic [W-1:0]  res
);
    logic [PW-1:0] diff;

    always_comb begin
        diff = acc - PW'(nmod);
        res  = (acc >= PW'(nmod)) ? diff[W-1:0] : acc[W-1:0];
    end
endmodule

// File: rtl/mont_exp_systolic.sv
module mont_exp_systolic
    import mexp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] msg,
    input  logic [W-1:0] expo,
    input  logic [W-1:0] modulus,
    input  logic [W-1:0] mod_half,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    localparam int PW = W + 2;
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] iter;
        logic [CW-1:0] step;
        logic          slot;
        logic [W-1:0]  a;
        logic [W-1:0]  b;
        logic [W-1:0]  sa;
        logic [W-1:0]  sb;
        logic [W-1:0]  esh;
        logic [W-1:0]  nmod;
        logic [W-1:0]  nhalf;
        logic [W-1:0]  res;
        logic [PW-1:0] p0;
        logic [PW-1:0] p1;
        logic          done;
    } st_t;

    st_t st_q, st_d;

    logic [PW-1:0] p_sel;
    logic          bit_sel;
    logic [PW-1:0] p_nx;
    logic [PW-1:0] acc_v [2];
    logic [W-1:0]  red_v [2];
    logic          sq_act;
    logic          mul_act;
    logic [W-1:0]  mod_lat;

    assign p_sel   = st_q.slot ? st_q.p1 : st_q.p0;
    assign bit_sel = st_q.slot ? st_q.sb[0] : st_q.sa[0];

    mexp_step #(.W(W), .PW(PW)) u_step (
        .p_in    (p_sel),
        .ser_bit (bit_sel),
        .par_op  (st_q.a),
        .nhalf   (st_q.nhalf),
        .p_out   (p_nx)
    );

    assign acc_v[0] = st_q.p0;
    assign acc_v[1] = st_q.p1;

    for (genvar g = 0; g < 2; g++) begin : g_red
        mexp_reduce #(.W(W), .PW(PW)) u_red (
            .acc  (acc_v[g]),
            .nmod (st_q.nmod),
            .res  (red_v[g])
        );
    end

    assign sq_act  = (st_q.iter != LAST);
    assign mul_act = (st_q.iter != CW'(1)) && st_q.esh[0];

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.ph    = PH_RUN;
                    st_d.iter  = CW'(1);
                    st_d.step  = '0;
                    st_d.slot  = 1'b0;
                    st_d.a     = msg;
                    st_d.b     = expo[0] ? msg : W'(1);
                    st_d.sa    = st_d.a;
                    st_d.sb    = st_d.b;
                    st_d.esh   = expo;
                    st_d.nmod  = modulus;
                    st_d.nhalf = mod_half;
                    st_d.p0    = '0;
                    st_d.p1    = '0;
                end
            end
            PH_RUN: begin
                if (!st_q.slot) begin
                    st_d.p0   = p_nx;
                    st_d.sa   = st_q.sa >> 1;
                    st_d.slot = 1'b1;
                end else begin
                    st_d.p1   = p_nx;
                    st_d.sb   = st_q.sb >> 1;
                    st_d.slot = 1'b0;
                    if (st_q.step == LAST) begin
                        st_d.ph = PH_WRAP;
                    end else begin
                        st_d.step = st_q.step + CW'(1);
                    end
                end
            end
            PH_WRAP: begin
                if (sq_act)  st_d.a = red_v[0];
                if (mul_act) st_d.b = red_v[1];
                st_d.esh  = st_q.esh >> 1;
                st_d.p0   = '0;
                st_d.p1   = '0;
                st_d.step = '0;
                st_d.slot = 1'b0;
                st_d.sa   = st_d.a;
                st_d.sb   = st_d.b;
                if (st_q.iter == LAST) begin
                    st_d.ph   = PH_IDLE;
                    st_d.res  = st_d.b;
                    st_d.done = 1'b1;
                end else begin
                    st_d.ph   = PH_RUN;
                    st_d.iter = st_q.iter + CW'(1);
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = (st_q.ph != PH_IDLE);
    assign done    = st_q.done;
    assign result  = st_q.res;
    assign mod_lat = st_q.nmod;
endmodule

// File: rtl/mexp_checker.sv
module mexp_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result,
    input logic [W-1:0] nmod
);
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_result_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result < nmod));

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
endmodule

bind mont_exp_systolic mexp_checker #(.W(W)) u_mexp_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result),
    .nmod   (mod_lat)
);

// File: tb/tb_mont_exp_systolic.sv
module tb_mont_exp_systolic;
    localparam int W = 8;
    localparam int T = W * (2 * W + 3);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] msg = '0;
    logic [W-1:0] expo = '0;
    logic [W-1:0] modulus = W'(3);
    logic [W-1:0] mod_half = W'(2);
    logic         busy;
    logic         done;
    logic [W-1:0] result;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    mont_exp_systolic #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .msg(msg), .expo(expo),
        .modulus(modulus), .mod_half(mod_half),
        .busy(busy), .done(done), .result(result)
    );

    function automatic longint mont(longint x, longint y, longint n);
        longint r = x * y;
        for (int i = 0; i < W; i++) begin
            if ((r % 2) != 0) r = r + n;
            r = r / 2;
        end
        return r % n;
    endfunction

    function automatic longint mexp_ref(longint m, longint e, longint n);
        longint a = m;
        longint b = ((e % 2) != 0) ? m : 1;
        for (int i = 1; i < W; i++) begin
            a = mont(a, a, n);
            if (((e >> i) % 2) != 0) b = mont(a, b, n);
        end
        return b;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // cycle model
    bit     m_busy = 1'b0;
    bit     m_done = 1'b0;
    longint m_res = 0;
    longint m_exp = 0;
    int     m_cnt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_done = 1'b0; m_res = 0; m_cnt = 0;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == T) begin
                    m_busy = 1'b0; m_done = 1'b1; m_res = m_exp;
                end
            end else if (start) begin
                m_busy = 1'b1; m_cnt = 0;
                m_exp = mexp_ref(longint'(msg), longint'(expo), longint'(modulus));
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == m_busy, "R2 busy", longint'(busy), longint'(m_busy));
            check(done == m_done, "R3 done", longint'(done), longint'(m_done));
            if (m_done)
                check(longint'(result) == m_res, "R4 result", longint'(result), m_res);
            else
                check(longint'(result) == m_res, "R7 hold", longint'(result), m_res);
        end
    end

    task automatic run(input longint m, input longint e, input longint n,
                       input bit disturb, input string tag);
        longint expv = mexp_ref(m, e, n);
        @(negedge clk);
        msg = W'(m); expo = W'(e); modulus = W'(n); mod_half = W'((n + 1) / 2);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            repeat (10) @(negedge clk);
            start = 1'b1;                          // R6: ignored while busy
            msg = W'($urandom); expo = W'($urandom);   // R10: no effect
            modulus = W'($urandom | 1); mod_half = W'($urandom);
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        check(longint'(result) == expv, tag, longint'(result), expv);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy", longint'(busy), 0);
        check(done == 1'b0, "R1 done", longint'(done), 0);
        check(result == '0, "R1 result", longint'(result), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && result == '0, "R1 after release", longint'(result), 0);

        run(77, 0, 101, 1'b0, "R5 zero exponent");
        check(result == W'(1), "R5 one", longint'(result), 1);
        run(77, 1, 101, 1'b0, "R5 bit0 only");
        check(result == W'(77), "R5 msg", longint'(result), 77);
        run(200, 255, 251, 1'b0, "R8 all ones");
        run(254, 255, 255, 1'b0, "R9 max modulus");
        run(2, 173, 3, 1'b0, "R9 min modulus");
        run(123, 182, 241, 1'b1, "R6 R10 disturbed");
        repeat (5) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R7 idle", longint'(busy), 0);

        for (int k = 0; k < 30; k++) begin
            longint n = 3 + 2 * longint'($urandom % 127);
            longint m = longint'($urandom) % n;
            longint e = longint'($urandom % 256);
            run(m, e, n, (k % 5) == 0, "R4 random");
        end

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule